// File: doc/BRIEF.md
# Reference Clock Loss Power Controller

This block sets the power state of one end of a serial link. A two-bit mode select chooses the power level. When both select bits are low, the link is fully powered down. Any other value brings the link up: a wait for PLL lock runs first, and parallel data is allowed only after that wait ends. The controller runs on a free-running system clock. It samples the reference clock through a two-flop synchronizer and watches it for edges.

If the reference stops at a constant level for too long, the controller enters a light sleep. In light sleep the PLL and the serial I/O are switched off, but the internal references stay powered. The first edge that follows wakes the link. It then relocks using a shorter count than a start from full power-down needs.

Leaving full power-down drives a short low pulse on the parallel-clock output. The analog PLL, the references and the I/O buffers appear here only as enable outputs.

Top module: `refclk_power_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: state is OFF, pll_en, serio_en, iref_en and data_valid are low, and pclk_out is high.
- R2: A mode select of 0 forces state OFF on the next clock, from any state. In OFF, pll_en, serio_en and iref_en are low, and edges on the reference input have no effect.
- R3: In OFF with a nonzero mode select, a synchronized reference edge (of either polarity) moves the state to LOCKING. In LOCKING, pll_en, serio_en and iref_en are all high.
- R4: After entry from OFF, LOCKING moves to ACTIVE on the LOCK_COLD-th synchronized rising reference edge. The edge that caused the entry is not counted. data_valid is high exactly when the state is ACTIVE.
- R5: In LOCKING or ACTIVE, if STALL_CYCLES consecutive system clocks pass with no synchronized reference edge, the state moves to STALLED. In STALLED, pll_en and serio_en are low and iref_en is high.
- R6: In STALLED, the first synchronized reference edge moves the state to LOCKING. ACTIVE then follows on the LOCK_WARM-th rising edge after that wake edge, where LOCK_WARM is smaller than LOCK_COLD.
- R7: pclk_out is low for exactly PULSE_LEN system clocks, starting at the transition from OFF to LOCKING. At all other times it is high.
- R8: state_o uses this encoding: OFF = 0, LOCKING = 1, ACTIVE = 2, STALLED = 3.
- R9: Changing the mode select from one nonzero value to another nonzero value has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Power mode select; 0 means full power-down |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk |
| pll_en | output | 1 | PLL enable |
| serio_en | output | 1 | Serial I/O enable |
| iref_en | output | 1 | Internal reference enable |
| pclk_out | output | 1 | Parallel-clock level, low briefly after leaving OFF |
| state_o | output | 2 | Power state encoding |
| data_valid | output | 1 | Parallel data may be accepted |

## Verification
Assertions check several rules on every cycle:
- a zero mode select always lands in OFF;
- ACTIVE is entered only from LOCKING;
- a stall while powered always leads to STALLED;
- STALLED exits only to LOCKING or OFF;
- the low pulse on pclk_out starts only when leaving OFF;
- the lock counter stays within bounds.

The exact relock lengths (cold versus warm), the exact pulse width, the fact that reference edges in OFF are ignored, and the fact that nonzero mode changes have no effect can only be shown by the bench. It does this with directed scenarios and with random runs of toggling, stalling and mode changes, compared against its own cycle model.

// File: rtl/refclk_power_ctrl.sv
module refclk_power_ctrl #(
  parameter int STALL_CYCLES = 64,
  parameter int LOCK_COLD    = 1024,
  parameter int LOCK_WARM    = 128,
  parameter int PULSE_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_clk_in,
  output logic       pll_en,
  output logic       serio_en,
  output logic       iref_en,
  output logic       pclk_out,
  output logic [1:0] state_o,
  output logic       data_valid
);
  localparam int IW   = $clog2(STALL_CYCLES + 1);
  localparam int LMAX = (LOCK_COLD > LOCK_WARM) ? LOCK_COLD : LOCK_WARM;
  localparam int LW   = $clog2(LMAX + 1);
  localparam int PW   = $clog2(PULSE_LEN + 1);

  localparam logic [1:0] ST_OFF     = 2'd0;
  localparam logic [1:0] ST_LOCKING = 2'd1;
  localparam logic [1:0] ST_ACTIVE  = 2'd2;
  localparam logic [1:0] ST_STALLED = 2'd3;

  logic          ref_s1, ref_s2, ref_d;
  logic [IW-1:0] idle_q;
  logic [LW-1:0] lock_left;
  logic [PW-1:0] pulse_q;
  logic [1:0]    state_q;

  wire ref_edge  = ref_s2 ^ ref_d;
  wire ref_rise  = ref_s2 & ~ref_d;
  wire powered   = |mode_sel;
  wire stall_now = !ref_edge && (idle_q >= IW'(STALL_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1 <= 1'b0;
      ref_s2 <= 1'b0;
      ref_d  <= 1'b0;
    end else begin
      ref_s1 <= ref_clk_in;
      ref_s2 <= ref_s1;
      ref_d  <= ref_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_q <= '0;
    else if (ref_edge)
      idle_q <= '0;
    else if (idle_q != IW'(STALL_CYCLES))
      idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      lock_left <= '0;
      pulse_q   <= '0;
    end else begin
      if (pulse_q != '0)
        pulse_q <= pulse_q - 1'b1;
      if (!powered) begin
        state_q <= ST_OFF;
      end else begin
        case (state_q)
          ST_OFF:
            if (ref_edge) begin
              state_q   <= ST_LOCKING;
              lock_left <= LW'(LOCK_COLD);
              pulse_q   <= PW'(PULSE_LEN);
            end
          ST_LOCKING:
            if (stall_now)
              state_q <= ST_STALLED;
            else if (ref_rise) begin
              if (lock_left <= LW'(1))
                state_q <= ST_ACTIVE;
              else
                lock_left <= lock_left - 1'b1;
            end
          ST_ACTIVE:
            if (stall_now)
              state_q <= ST_STALLED;
          default:
            if (ref_edge) begin
              state_q   <= ST_LOCKING;
              lock_left <= LW'(LOCK_WARM);
            end
        endcase
      end
    end
  end

  assign state_o    = state_q;
  assign pll_en     = (state_q == ST_LOCKING) || (state_q == ST_ACTIVE);
  assign serio_en   = pll_en;
  assign iref_en    = (state_q != ST_OFF);
  assign data_valid = (state_q == ST_ACTIVE);
  assign pclk_out   = (pulse_q == '0);

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |=> (state_q == ST_OFF));

  // R4
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ACTIVE) |-> $past(state_q == ST_LOCKING));

  // R5
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && stall_now && pll_en) |=> (state_q == ST_STALLED));

  // R6
  stalled_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STALLED) |=> (state_q == ST_STALLED || state_q == ST_LOCKING || state_q == ST_OFF));

  // R7
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_out) |-> $past(state_q == ST_OFF));

  // R4
  lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_left <= LW'(LMAX));
endmodule

// File: tb/test_refclk_power_ctrl.sv
module test_refclk_power_ctrl;
  localparam int STALL = 16, COLD = 40, WARM = 10, PULSE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic ref_clk_in = 1'b0;
  logic pll_en, serio_en, iref_en, pclk_out, data_valid;
  logic [1:0] state_o;
  int total = 0, bad = 0, cycles = 0;

  refclk_power_ctrl #(.STALL_CYCLES(STALL), .LOCK_COLD(COLD), .LOCK_WARM(WARM), .PULSE_LEN(PULSE))
    i_refclk_power_ctrl (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_clk_in(ref_clk_in),
      .pll_en(pll_en), .serio_en(serio_en), .iref_en(iref_en), .pclk_out(pclk_out),
      .state_o(state_o), .data_valid(data_valid));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent cycle model derived from the requirements
  logic m_s1, m_s2, m_d;
  int m_idle, m_lock, m_pulse;
  logic [1:0] m_st;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_d <= 0; m_idle <= 0; m_lock <= 0; m_pulse <= 0; m_st <= 0;
    end else begin
      automatic bit e = m_s2 ^ m_d;
      automatic bit r = m_s2 & ~m_d;
      automatic bit st = !e && (m_idle >= STALL - 1);
      m_s1 <= ref_clk_in; m_s2 <= m_s1; m_d <= m_s2;
      m_idle <= e ? 0 : (m_idle < STALL ? m_idle + 1 : m_idle);
      if (m_pulse > 0) m_pulse <= m_pulse - 1;
      if (mode_sel == 2'd0) m_st <= 2'd0;
      else case (m_st)
        2'd0: if (e) begin m_st <= 2'd1; m_lock <= COLD; m_pulse <= PULSE; end
        2'd1: if (st) m_st <= 2'd3;
              else if (r) begin
                if (m_lock <= 1) m_st <= 2'd2; else m_lock <= m_lock - 1;
              end
        2'd2: if (st) m_st <= 2'd3;
        default: if (e) begin m_st <= 2'd1; m_lock <= WARM; end
      endcase
    end
  end

  function automatic bit exp_pll(input logic [1:0] s); return s == 2'd1 || s == 2'd2; endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(state_o == m_st, "R8 state", state_o, m_st);
      chk(data_valid == (m_st == 2'd2), "R4 data_valid", data_valid, m_st == 2'd2);
      chk(pll_en == exp_pll(m_st) && serio_en == exp_pll(m_st), "R5 pll/serio", pll_en, exp_pll(m_st));
      chk(iref_en == (m_st != 2'd0), "R5 iref_en", iref_en, m_st != 2'd0);
      chk(pclk_out == (m_pulse == 0), "R7 pclk_out", pclk_out, m_pulse == 0);
    end
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_rises_to_active(output int n);
    n = 0;
    while (!data_valid && n < 2000) begin
      ref_clk_in = 1'b1; n++;
      wait_n(2);
      ref_clk_in = 1'b0;
      wait_n(2);
    end
  endtask

  initial begin
    int n, lows;
    void'($urandom(32'd20240611));
    wait_n(2);
    // R1
    chk(state_o == 2'd0 && !pll_en && !serio_en && !iref_en && !data_valid && pclk_out,
        "R1 reset outputs", {state_o, pll_en, iref_en, pclk_out}, 5'b00001);
    @(negedge clk) rst_n = 1'b1;
    wait_n(2);
    // R3 / R7: wake from OFF, count low cycles of pclk_out
    mode_sel = 2'd1;
    ref_clk_in = 1'b1;
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!pclk_out) lows++;
    end
    chk(lows == PULSE, "R7 pulse width", lows, PULSE);
    chk(state_o == 2'd1 && pll_en && serio_en && iref_en, "R3 locking enables", state_o, 1);
    ref_clk_in = 1'b0;
    wait_n(2);
    // R4: cold relock length
    count_rises_to_active(n);
    chk(n == COLD, "R4 cold lock rises", n, COLD);
    // R9
    mode_sel = 2'd2; wait_n(2); mode_sel = 2'd3; wait_n(2);
    chk(state_o == 2'd2, "R9 nonzero mode change", state_o, 2);
    // R5: stall low
    wait_n(STALL + 4);
    chk(state_o == 2'd3 && !pll_en && !serio_en && iref_en, "R5 stalled enables", state_o, 3);
    // R6: warm relock length, wake rise included
    count_rises_to_active(n);
    chk(n == WARM + 1, "R6 warm lock rises", n, WARM + 1);
    // R2: OFF ignores reference edges
    mode_sel = 2'd0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) ref_clk_in = ~ref_clk_in;
    end
    wait_n(4);
    chk(state_o == 2'd0 && !iref_en && !pll_en, "R2 off ignores ref", state_o, 0);
    // random segments
    for (int seg = 0; seg < 60; seg++) begin
      int kind = $urandom_range(0, 5);
      if ($urandom_range(0, 7) == 0) mode_sel = 2'd0;
      else mode_sel = 2'($urandom_range(1, 3));
      if (kind < 4) begin
        int half = $urandom_range(1, 3);
        int len = $urandom_range(20, 300);
        for (int c = 0; c < len; c++) begin
          @(negedge clk);
          if (c % half == 0) ref_clk_in = ~ref_clk_in;
        end
      end else begin
        wait_n($urandom_range(5, 40));
      end
    end
    wait_n(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule